// File: doc/BRIEF.md
# Latched Eight-Way Bit Selector with Complementary Floating Outputs

The block picks one bit out of eight sources and presents it on a true output and an inverted output. Both the candidate data and the 3-bit select code pass through their own capture stage. Each stage follows its inputs while its active-low hold control is LOW and freezes when that control goes HIGH. A full binary decode of the stored code chooses exactly one stored data bit.

A three-input output gate controls whether the outputs are driven. Two of its inputs are active LOW and one is active HIGH. When the gate is closed, both outputs float. Operating the gate never touches the stored data or the stored code.

The capture stages are clock-enabled registers rather than level latches. The outputs are registered. A synchronous active-high reset clears everything. Every result therefore appears two clock edges after the input that caused it.

Top module: `latched_selector`

## Requirements
- R1: Reset clears the stored data, the stored code and the gate, so `drive_en` is 0. When the gate is then opened with both stages holding, `y` is 0 and `y_n` is 1.
- R2: The code stage loads `sel` at every rising clock edge while `addr_hold_n` is 0. It keeps its value while `addr_hold_n` is 1, so a change on `sel` does not reach the outputs.
- R3: The data stage loads `din` at every rising clock edge while `data_hold_n` is 0. It keeps its value while `data_hold_n` is 1, so a change on `din` does not reach the outputs.
- R4: `y` equals bit `k` of the stored data, where `k` is the stored code read as an unsigned number. Bit `k` of `din` is source `k`. The result is due two rising edges after the inputs are presented.
- R5: Whenever `drive_en` is 1, `y_n` is the complement of `y`.
- R6: `drive_en` is 1 exactly when `oe_a_n`=0, `oe_b_n`=0 and `oe_c`=1, two edges after the gate inputs are presented. When `drive_en` is 0, `y` and `y_n` are high impedance.
- R7: Changing the three gate inputs leaves both stored values unchanged. When the gate is reopened, it shows the value that was held before.
- R8: When a hold control rises, the stage keeps the input that was present at the last edge on which it was still open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Eight data sources; bit k is source k |
| sel | input | 3 | Select code |
| data_hold_n | input | 1 | Data stage follows `din` while LOW, holds while HIGH |
| addr_hold_n | input | 1 | Code stage follows `sel` while LOW, holds while HIGH |
| oe_a_n | input | 1 | Output gate, active LOW |
| oe_b_n | input | 1 | Output gate, active LOW |
| oe_c | input | 1 | Output gate, active HIGH |
| y | output | 1 | Selected bit, or high impedance |
| y_n | output | 1 | Inverse of the selected bit, or high impedance |
| drive_en | output | 1 | 1 while the outputs are driven |

## Verification
Data, code and gate inputs each pass one capture register and then one output register. Every result therefore falls due at the second rising edge after its stimulus. The bench drives inputs on falling edges and samples two falling edges later.

The random phase runs a bench-side model with the same two-edge timing and compares against it every cycle. The directed cases hold one stage and change its input. They then wait at least the same two edges before confirming that the output kept the stored value.

// File: rtl/selq_pkg.sv
package selq_pkg;
  // Output gate opens only for the single enabling combination.
  function automatic logic gate_open(input logic a_n, input logic b_n, input logic c);
    return (~a_n) & (~b_n) & c;
  endfunction
endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (!load_n) q <= d;
  end

  // R2/R3: holding stage keeps its contents
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(load_n)) |-> $stable(q));

  // R8: value kept equals the input seen at the last open edge
  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(load_n)) |-> (q == $past(d)));
endmodule

// File: rtl/onehot_mux.sv
module onehot_mux #(
  parameter int N  = 8,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  data,
  input  logic [SW-1:0] code,
  output logic          bit_out
);
  logic [N-1:0] dec;
  logic [N-1:0] pick;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign dec[i]  = (code == SW'(i));
    assign pick[i] = dec[i] & data[i];
  end

  assign bit_out = |pick;

  // R4: full decode gives at most one active line
  a_r4_onehot_decode: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dec));
endmodule

// File: rtl/drive_stage.sv
module drive_stage (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic gate_in,
  output logic y,
  output logic y_n,
  output logic drive_en
);
  logic y_q;
  logic drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      y_q   <= bit_in;
      drv_q <= gate_in;
    end
  end

  assign y        = drv_q ? y_q  : 1'bz;
  assign y_n      = drv_q ? ~y_q : 1'bz;
  assign drive_en = drv_q;

  // R6: drive flag follows the registered gate one edge later
  a_r6_drive_follow: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (drive_en == $past(gate_in)));
endmodule

// File: rtl/latched_selector.sv
module latched_selector #(
  parameter int N  = 8,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  din,
  input  logic [SW-1:0] sel,
  input  logic          data_hold_n,
  input  logic          addr_hold_n,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  input  logic          oe_c,
  output logic          y,
  output logic          y_n,
  output logic          drive_en
);
  import selq_pkg::*;

  logic [N-1:0]  data_q;
  logic [SW-1:0] code_q;
  logic          gate_q;
  logic          picked;

  capture_reg #(.W(N)) u_data (
    .clk(clk), .rst(rst), .load_n(data_hold_n), .d(din), .q(data_q));

  capture_reg #(.W(SW)) u_code (
    .clk(clk), .rst(rst), .load_n(addr_hold_n), .d(sel), .q(code_q));

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_open(oe_a_n, oe_b_n, oe_c);
  end

  onehot_mux #(.N(N), .SW(SW)) u_mux (
    .clk(clk), .rst(rst), .data(data_q), .code(code_q), .bit_out(picked));

  drive_stage u_drive (
    .clk(clk), .rst(rst), .bit_in(picked), .gate_in(gate_q),
    .y(y), .y_n(y_n), .drive_en(drive_en));

  // R6: gate pins reach drive_en two edges later
  a_r6_gate_latency: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rst, 2)) |->
      (drive_en == $past((!oe_a_n) && (!oe_b_n) && oe_c, 2)));

  // R7: gate activity never moves the stored data while it is held
  a_r7_gate_isolated: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(data_hold_n) && $past(addr_hold_n)) |->
      ($stable(data_q) && $stable(code_q)));

  // R4: registered output equals stored bit chosen by stored code
  a_r4_select: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && drive_en) |-> (y == $past(data_q[code_q])));

  // R5: complementary outputs while driven
  a_r5_complement: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> (y_n == !y));
endmodule

// File: tb/tb_latched_selector.sv
`timescale 1ns/1ps
module tb_latched_selector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic [2:0] sel = '0;
  logic       data_hold_n = 1'b1;
  logic       addr_hold_n = 1'b1;
  logic       oe_a_n = 1'b1;
  logic       oe_b_n = 1'b1;
  logic       oe_c   = 1'b0;
  wire        y, y_n, drive_en;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  latched_selector dut (
    .clk(clk), .rst(rst), .din(din), .sel(sel),
    .data_hold_n(data_hold_n), .addr_hold_n(addr_hold_n),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .oe_c(oe_c),
    .y(y), .y_n(y_n), .drive_en(drive_en));

  // Bench model built from R2, R3, R4, R6: capture stage then output stage.
  logic [7:0] m_data;
  logic [2:0] m_code;
  logic       m_gate, e_y, e_drv;

  function automatic logic exp_gate(input logic a_n, input logic b_n, input logic c);
    return (a_n == 1'b0) && (b_n == 1'b0) && (c == 1'b1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_data <= '0; m_code <= '0; m_gate <= 1'b0; e_y <= 1'b0; e_drv <= 1'b0;
    end else begin
      if (!data_hold_n) m_data <= din;
      if (!addr_hold_n) m_code <= sel;
      m_gate <= exp_gate(oe_a_n, oe_b_n, oe_c);
      e_y    <= m_data[m_code];
      e_drv  <= m_gate;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_gate(input logic a_n, input logic b_n, input logic c);
    oe_a_n = a_n; oe_b_n = b_n; oe_c = c;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R1 drive_en in reset", drive_en, 1'b0);
    rst = 1'b0;
    step(2);
    check("R1 drive_en after reset", drive_en, 1'b0);
    set_gate(1'b0, 1'b0, 1'b1);
    step(2);
    check("R1 drive_en gate open", drive_en, 1'b1);
    check("R1 y cleared", y, 1'b0);
    check("R1 y_n cleared", y_n, 1'b1);

    // R4: sweep every select code with both stages open
    din = 8'b1010_0110; data_hold_n = 1'b0; addr_hold_n = 1'b0;
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      step(2);
      check($sformatf("R4 code %0d", s), y, din[s]);
      check($sformatf("R5 code %0d", s), y_n, ~din[s]);
    end

    // R2 / R8: code stage closes holding the last open value (3)
    sel = 3'd3;             // din[3]=0
    step(1);
    addr_hold_n = 1'b1; sel = 3'd5; // din[5]=1 would differ
    step(3);
    check("R2 code held", y, 1'b0);
    check("R8 code capture", y_n, 1'b1);
    sel = 3'd1;             // din[1]=1 would differ
    step(2);
    check("R2 sel change ignored", y, 1'b0);

    // R3 / R8: data stage closes on 8'h08, code held at 3
    din = 8'h08;
    step(1);
    data_hold_n = 1'b1; din = 8'h00;
    step(3);
    check("R8 data capture", y, 1'b1);
    din = 8'hF7;
    step(2);
    check("R3 din change ignored", y, 1'b1);

    // R6 / R7: all eight gate combinations with both stages holding
    for (int g = 0; g < 8; g++) begin
      set_gate(g[2], g[1], g[0]);
      step(2);
      check($sformatf("R6 gate %0d", g), drive_en, (g == 1));
    end
    set_gate(1'b0, 1'b0, 1'b1);
    step(2);
    check("R7 value after gate activity", y, 1'b1);
    check("R7 inverse after gate activity", y_n, 1'b0);

    // Random phase against the bench model (R4, R5, R6)
    void'($urandom(32'd12345));
    for (int i = 0; i < 400; i++) begin
      din         = 8'($urandom);
      sel         = 3'($urandom);
      data_hold_n = ($urandom % 3) == 0;
      addr_hold_n = ($urandom % 3) == 0;
      if (($urandom % 4) == 0) set_gate(1'($urandom), 1'($urandom), 1'($urandom));
      else                     set_gate(1'b0, 1'b0, 1'b1);
      step(1);
      check("R6 random drive_en", drive_en, e_drv);
      if (e_drv) begin
        check("R4 random y", y, e_y);
        check("R5 random y_n", y_n, ~e_y);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule